// File: doc/BRIEF.md
# Serial Engine Run-State Controller

This block holds the run state of a serial peripheral engine and lets software move it between three states: idle-reset, running and paused. Software talks to it through a single-cycle register port. A status bit tells software when the engine is settled and ready for the next state request, and the current state is driven straight to the datapath on a dedicated output.

A state request is made by a read-modify-write of the low two bits of the control word. The upper bits of that word are general-purpose storage that is kept across requests. Every accepted request drops the ready bit for a programmable number of cycles. Leaving the paused state for idle-reset needs two back-to-back clear requests, so a single stray clear cannot stop a paused engine. A separate software-reset register returns the engine to idle-reset at once and wipes the two configuration registers that sit beside it.

The block is used by a driver that polls the ready bit before each request. A request made while the bit is low is discarded and recorded in a sticky error flag, which a software reset clears.

Top module: `sereng_runstate`

## Requirements
- R1: After synchronous active-low reset, the state field reads 0 (idle-reset), the ready bit (control word bit 2) reads 1, the error flag (bit 3) reads 0, and the registers at addresses 2 and 3 read 0.
- R2: The control word is at address 0. Its bits [1:0] hold the state, coded 0 = idle-reset, 1 = run, 3 = paused. An accepted write updates `run_state` and the state field at the next clock edge. Bits [DATA_W-1:4] of an accepted write are stored and read back unchanged.
- R3: After an accepted control-word write, `state_valid` is low for exactly SETTLE_CYCLES clock cycles and then high again.
- R4: A control-word write made while `state_valid` is low leaves the state and the stored upper bits unchanged and sets the error flag. The flag stays set through later accepted writes.
- R5: From paused, a first write of code 0 leaves the state at paused but still drops `state_valid`. A second code-0 write, with no other control-word write in between, moves the state to idle-reset.
- R6: From paused with one clear already received, any other accepted state code cancels the pending clear. After that, a single code-0 write again leaves the state at paused.
- R7: A control-word write of the reserved code 2 is ignored. The state, the upper bits and `state_valid` are all unchanged.
- R8: Writing 1 to bit 0 at address 1 forces idle-reset at the next edge. It also clears the registers at addresses 2 and 3 and the error flag, and leaves `state_valid` high. A write with bit 0 clear at address 1 has no effect. Address 1 reads as 0.
- R9: The registers at addresses 2 (operational flags) and 3 (mode) are plain read/write registers of DATA_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| run_state | output | 2 | Current engine state for the datapath |
| state_valid | output | 1 | High when the last state change has settled |

## Verification
A wrong pause-clear arm bit shows up as a paused engine that drops to idle-reset on the first clear request, or that never leaves paused. Either is visible on `run_state` one edge after the second request. A settle counter that is off by one moves the rising edge of `state_valid` by a cycle, so the bench counts the low cycles after each accepted request. A lost error flag or a missed configuration clear appears on the next read of the affected register.

// File: rtl/sereng_rs_pkg.sv
package sereng_rs_pkg;

   typedef enum logic [1:0] {
      RS_IDLE  = 2'd0,
      RS_RUN   = 2'd1,
      RS_RSVD  = 2'd2,
      RS_PAUSE = 2'd3
   } rs_state_e;

   // register map (address decode is behaviour a driver relies on)
   localparam int unsigned A_CTRL  = 0;
   localparam int unsigned A_SWRST = 1;
   localparam int unsigned A_OPFLG = 2;
   localparam int unsigned A_MODE  = 3;

   // control word layout
   localparam int unsigned B_READY = 2;
   localparam int unsigned B_ERR   = 3;
   localparam int unsigned B_AUX   = 4;

   localparam int unsigned NUM_CFG = 2;

endpackage

// File: rtl/sereng_settle_timer.sv
module sereng_settle_timer #(
   parameter int unsigned SETTLE_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic clear,
   output logic ready
);
   localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYCLES);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= LOAD_VAL;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign ready = (cnt_q == '0);

endmodule

// File: rtl/sereng_state_fsm.sv
module sereng_state_fsm
   import sereng_rs_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              swrst,
   input  logic              wr_ctrl,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ready,
   output rs_state_e         state_q,
   output logic [DATA_W-5:0] aux_q,
   output logic              err_q,
   output logic              accept
);
   rs_state_e req;
   logic      armed_q;
   logic      drop;

   assign req    = rs_state_e'(wdata[1:0]);
   assign drop   = wr_ctrl && !ready;
   assign accept = wr_ctrl && ready && (req != RS_RSVD) && !swrst;

   always_ff @(posedge clk) begin
      if (!rst_n || swrst) begin
         state_q <= RS_IDLE;
         aux_q   <= '0;
         err_q   <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (drop) begin
            err_q <= 1'b1;
         end
         if (accept) begin
            aux_q <= wdata[DATA_W-1:B_AUX];
            if (state_q == RS_PAUSE && req == RS_IDLE) begin
               // leaving pause needs a second clear in a row
               if (armed_q) begin
                  state_q <= RS_IDLE;
                  armed_q <= 1'b0;
               end else begin
                  armed_q <= 1'b1;
               end
            end else begin
               state_q <= req;
               armed_q <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/sereng_cfg_regs.sv
module sereng_cfg_regs #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NUM    = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clear,
   input  logic [NUM-1:0]             wr_sel,
   input  logic [DATA_W-1:0]          wdata,
   output logic [NUM-1:0][DATA_W-1:0] q
);
   for (genvar i = 0; i < NUM; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n || clear) begin
            q[i] <= '0;
         end else if (wr_sel[i]) begin
            q[i] <= wdata;
         end
      end
   end

endmodule

// File: rtl/sereng_runstate.sv
module sereng_runstate
   import sereng_rs_pkg::*;
#(
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned ADDR_W        = 2,
   parameter int unsigned SETTLE_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [1:0]        run_state,
   output logic              state_valid
);
   if (DATA_W < 8) begin : g_bad_width
      $error("sereng_runstate: DATA_W must be at least 8");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("sereng_runstate: ADDR_W must be at least 2");
   end
   if (SETTLE_CYCLES < 1) begin : g_bad_settle
      $error("sereng_runstate: SETTLE_CYCLES must be at least 1");
   end

   logic wr_ctrl, swrst, ready, accept, err_q;
   logic [NUM_CFG-1:0]             cfg_wr;
   logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q;
   logic [DATA_W-5:0]              aux_q;
   rs_state_e                      state_q;

   assign wr_ctrl   = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
   assign swrst     = reg_wr && (reg_addr == ADDR_W'(A_SWRST)) && reg_wdata[0];
   assign cfg_wr[0] = reg_wr && (reg_addr == ADDR_W'(A_OPFLG));
   assign cfg_wr[1] = reg_wr && (reg_addr == ADDR_W'(A_MODE));

   sereng_state_fsm #(.DATA_W(DATA_W)) i_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .swrst   (swrst),
      .wr_ctrl (wr_ctrl),
      .wdata   (reg_wdata),
      .ready   (ready),
      .state_q (state_q),
      .aux_q   (aux_q),
      .err_q   (err_q),
      .accept  (accept)
   );

   sereng_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .clear (swrst),
      .ready (ready)
   );

   sereng_cfg_regs #(.DATA_W(DATA_W), .NUM(NUM_CFG)) i_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (swrst),
      .wr_sel (cfg_wr),
      .wdata  (reg_wdata),
      .q      (cfg_q)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(A_CTRL)) begin
         reg_rdata = {aux_q, err_q, ready, state_q};
      end else if (reg_addr == ADDR_W'(A_OPFLG)) begin
         reg_rdata = cfg_q[0];
      end else if (reg_addr == ADDR_W'(A_MODE)) begin
         reg_rdata = cfg_q[1];
      end
   end

   assign run_state   = state_q;
   assign state_valid = ready;

endmodule

// File: rtl/sereng_runstate_chk.sv
module sereng_runstate_chk #(
   parameter int unsigned ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [1:0]        wcode,
   input logic              wbit0,
   input logic [1:0]        run_state,
   input logic              state_valid,
   input logic              err_flag
);
   logic wr_ctrl, wr_rst;
   assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(0));
   assign wr_rst  = reg_wr && (reg_addr == ADDR_W'(1)) && wbit0;

   p_settle_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && state_valid && wcode != 2'd2) |=> !state_valid);

   p_drop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !state_valid) |=> ($stable(run_state) && err_flag));

   p_rsvd_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && state_valid && wcode == 2'd2) |=> ($stable(run_state) && state_valid));

   p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      run_state != 2'd2);

   p_swrst_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rst |=> (run_state == 2'd0 && state_valid && !err_flag));

   p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !wr_rst) |=> err_flag);

endmodule

bind sereng_runstate sereng_runstate_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr      (reg_wr),
   .reg_addr    (reg_addr),
   .wcode       (reg_wdata[1:0]),
   .wbit0       (reg_wdata[0]),
   .run_state   (run_state),
   .state_valid (state_valid),
   .err_flag    (err_q)
);

// File: tb/test_sereng_runstate.sv
`timescale 1ns/1ps
module test_sereng_runstate;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned ADDR_W = 2;
   localparam int unsigned SETTLE = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic [1:0]        run_state;
   logic              state_valid;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sereng_runstate #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SETTLE_CYCLES(SETTLE)) i_sereng_runstate (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .run_state(run_state), .state_valid(state_valid)
   );

   // vector: [11:10] address, [9:2] write data, [1:0] expected state after settle
   localparam int NV = 14;
   localparam logic [11:0] VEC [NV] = '{
      {2'd0, 8'h11, 2'd1},  // R2 run
      {2'd0, 8'h03, 2'd3},  // R2 pause
      {2'd0, 8'h00, 2'd3},  // R5 first clear holds pause
      {2'd0, 8'h00, 2'd0},  // R5 second clear reaches idle
      {2'd0, 8'h01, 2'd1},  // R2 run
      {2'd0, 8'h02, 2'd1},  // R7 reserved ignored
      {2'd0, 8'h03, 2'd3},  // pause
      {2'd0, 8'h00, 2'd3},  // R5 armed
      {2'd0, 8'h01, 2'd1},  // R6 run cancels arm
      {2'd0, 8'h03, 2'd3},  // pause
      {2'd0, 8'h00, 2'd3},  // armed
      {2'd0, 8'h03, 2'd3},  // R6 pause rewrite cancels arm
      {2'd0, 8'h00, 2'd3},  // R6 single clear holds pause
      {2'd0, 8'h00, 2'd0}   // R5 pair completes
   };

   task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_ready();
      for (int i = 0; i < 50 && !state_valid; i++) @(negedge clk);
   endtask

   initial begin
      logic [DATA_W-1:0] d;
      int lows;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(0, d); check("R1 ctrl", d, 32'h4);
      rd(2, d); check("R1 opflags", d, 0);
      rd(3, d); check("R1 mode", d, 0);
      check("R1 run_state", {30'd0, run_state}, 0);

      // R3 settle length
      wr(0, 32'h1);
      lows = 0;
      for (int i = 0; i < 20 && !state_valid; i++) begin lows++; @(negedge clk); end
      check("R3 low cycles", lows, SETTLE);
      check("R2 run_state", {30'd0, run_state}, 1);

      // back to idle then walk the table
      wr(0, 32'h0); wait_ready();
      for (int v = 0; v < NV; v++) begin
         wr(VEC[v][11:10], {24'd0, VEC[v][9:2]});
         wait_ready();
         rd(0, d);
         check($sformatf("R2/R5/R6/R7 vector %0d", v), {30'd0, d[1:0]}, {30'd0, VEC[v][1:0]});
      end

      // R2 upper bits stored
      wr(0, 32'hABCD_1230 | 32'h1); wait_ready();
      rd(0, d); check("R2 aux readback", d, 32'hABCD_1235);

      // R7 reserved leaves aux and ready alone
      wr(0, 32'h5555_5552);
      rd(0, d); check("R7 reserved no effect", d, 32'hABCD_1235);

      // R4 write during settle
      wr(0, 32'h3);
      wr(0, 32'h0000_0F01);
      wait_ready();
      rd(0, d); check("R4 dropped write", d, 32'h0000_000C | 32'h3);
      wr(0, 32'h1); wait_ready();
      rd(0, d); check("R4 error sticky", d[3:0], 4'hD);

      // R9 config registers
      wr(2, 32'hDEAD_BEEF);
      wr(3, 32'h0123_4567);
      rd(2, d); check("R9 opflags", d, 32'hDEAD_BEEF);
      rd(3, d); check("R9 mode", d, 32'h0123_4567);

      // R8 write of 0 to reset register does nothing
      wr(1, 32'h0);
      rd(1, d); check("R8 reads zero", d, 0);
      rd(2, d); check("R8 no-op opflags", d, 32'hDEAD_BEEF);
      check("R8 no-op state", {30'd0, run_state}, 1);

      // R8 software reset during settle
      wr(0, 32'h3);
      wr(1, 32'h1);
      rd(0, d); check("R8 ctrl after swrst", d, 32'h4);
      rd(2, d); check("R8 opflags cleared", d, 0);
      rd(3, d); check("R8 mode cleared", d, 0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule